// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is a supervision timer for a low-power system. A 15-bit up-counter advances once for every enable pulse that arrives from a slow, low-power time base. The pulse is already synchronised to the system clock. The block runs in one of two modes.

As a system watchdog, it asks for a system reset if software lets the count reach the selected interval. Software prevents this by writing a two-step key into a 4-bit clear field. As a general interval timer, it raises a sticky interrupt flag each time the interval elapses, and forwards that flag as an interrupt request when an external enable allows it.

Software programs the block through a single write strobe that carries all control fields at once: enable, mode, a 2-bit interval select and the 4-bit clear field. A low-power-entry input zeroes the counter. The counter itself cannot be read.

Top module: `dual_watchdog`

## Requirements
- R1: After reset the block is disabled. `sys_rst_o`, `irq_flag_o` and `irq_o` are low, and no number of tick pulses produces a reset or a flag until a write sets enable to 1.
- R2: Interval select codes 2'b00, 2'b01, 2'b10 and 2'b11 give 64, 512, 8192 and 32768 ticks. The timeout or timer event happens on the tick that takes the count from zero up to that number.
- R3: With the mode field at 0 (watchdog), reaching the interval produces a `sys_rst_o` pulse exactly one clock wide. Watchdog mode never sets the interrupt flag.
- R4: In the clock cycle of the reset pulse, the block returns to its disabled state with mode 0 and interval select 0. Further ticks produce nothing until it is enabled again.
- R5: While enabled in watchdog mode, the enable and mode fields of a write are ignored. The interval select of the same write still takes effect.
- R6: In watchdog mode, a write of clear code 4'b1010 followed by a write of 4'b0101 in one of the next WIN_CYCLES system clocks zeroes the counter, and counting then continues.
- R7: A different clear code written between the two key writes cancels the pending sequence, and so does a 4'b0101 that comes later than WIN_CYCLES clocks after 4'b1010. A 4'b0101 with no sequence pending has no effect.
- R8: If the interval is reached while a key sequence is pending, the reset is held off. Completing the sequence clears the counter. If the window runs out instead, the reset is issued on the next tick.
- R9: With the mode field at 1 (timer), reaching the interval sets `irq_flag_o` and the counter wraps to zero. The flag stays set until `flag_clr_i`. `irq_o` follows the flag only while `irq_en_i` is 1. Timer mode never produces a reset.
- R10: In timer mode, a write with bit 0 of the clear field set zeroes the counter.
- R11: In timer mode, writing enable 0 stops counting. Writing enable 1 afterwards restarts the count from zero.
- R12: A pulse on `lp_entry_i` zeroes the counter.
- R13: If the interval select is lowered while the count already lies beyond the new interval, the event happens on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle enable pulse from the slow time base |
| lp_entry_i | input | 1 | Deep low-power entry; zeroes the counter |
| wr_i | input | 1 | Control register write strobe |
| wr_enable_i | input | 1 | Enable field of the write |
| wr_mode_i | input | 1 | Mode field: 0 watchdog, 1 timer |
| wr_intsel_i | input | 2 | Interval select field |
| wr_clr_i | input | 4 | Clear field (key codes or timer clear) |
| irq_en_i | input | 1 | External interrupt enable |
| flag_clr_i | input | 1 | Write-1-to-clear for the interrupt flag |
| sys_rst_o | output | 1 | One-cycle system reset request |
| irq_flag_o | output | 1 | Sticky timer interrupt flag |
| irq_o | output | 1 | Interrupt request, flag gated by `irq_en_i` |

## Verification
The bench probes both edges of the key window: a second key one clock late is rejected and one exactly on the limit is accepted. A design whose window is off by one would either leave a late clear in place or reset a system that cleared in time. It also starts a key sequence on the last count before timeout. A design that does not hold the timeout back would reset while software is still clearing, and one that never resumes would hang forever once the window runs out. Other tests try to disable or switch mode while the watchdog is locked, shrink the interval below the current count, and run timer mode with the interrupt enable off. A faulty design would, in turn, fail to fire, let the count run to wrap-around without firing, or leak an interrupt.

// File: rtl/wdt_pkg.sv
// Package: shared constants and helpers of the dual-mode watchdog.
// Assumes the counter is at least 15 bits so every interval fits.
package wdt_pkg;
    localparam logic       MODE_WD    = 1'b0;
    localparam logic       MODE_TMR   = 1'b1;
    localparam logic [3:0] KEY_FIRST  = 4'b1010;
    localparam logic [3:0] KEY_SECOND = 4'b0101;

    // Last count value before the event for a given interval select.
    function automatic logic [14:0] interval_last(input logic [1:0] sel);
        logic [14:0] last;
        case (sel)
            2'd0:    last = 15'd63;
            2'd1:    last = 15'd511;
            2'd2:    last = 15'd8191;
            default: last = 15'd32767;
        endcase
        return last;
    endfunction
endpackage

// File: rtl/wdt_key_seq.sv
// wdt_key_seq: tracks the two-step clear key in watchdog mode.
// A first-key write opens a window of WIN_CYCLES system clocks. A
// second-key write inside the window completes the sequence; any other
// write or the window running out cancels it. Assumes arm_i is low
// whenever the block is not locked in watchdog mode.
module wdt_key_seq #(
    parameter int WIN_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_i,
    input  logic       wr_i,
    input  logic [3:0] code_i,
    output logic       pending_o,
    output logic       done_o
);
    import wdt_pkg::*;

    localparam int WIN_W = $clog2(WIN_CYCLES + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

    logic             pending_q;
    logic [WIN_W-1:0] win_q;

    // Completion is recognised in the cycle of the second-key write.
    assign done_o    = wr_i && pending_q && (code_i == KEY_SECOND);
    assign pending_o = pending_q;

    // Window state: open, close or advance the pending sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm_i) begin
            pending_q <= 1'b0;
            win_q     <= '0;
        end else if (wr_i) begin
            if (code_i == KEY_FIRST) begin
                pending_q <= 1'b1;
                win_q     <= '0;
            end else begin
                pending_q <= 1'b0;
            end
        end else if (pending_q) begin
            if (win_q == WIN_LAST) begin
                pending_q <= 1'b0;
            end else begin
                win_q <= win_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_counter.sv
// wdt_counter: the hidden interval counter. It advances on tick_i while
// running and flags a match when a tick arrives with the count at or past
// the last value of the selected interval. On a match it wraps to zero,
// unless hold_i keeps it at its value. A stopped counter reads zero.
module wdt_counter #(
    parameter int CNT_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic       clear_i,
    input  logic       hold_i,
    input  logic [1:0] sel_i,
    output logic       match_o
);
    import wdt_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Compare against the interval limit; >= covers a lowered interval.
    always_comb begin
        last    = CNT_W'(interval_last(sel_i));
        match_o = run_i && tick_i && (cnt_q >= last);
    end

    // Count register: clear, stop, wrap or advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || clear_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (match_o) begin
                cnt_q <= hold_i ? cnt_q : '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_flag.sv
// wdt_flag: sticky timer interrupt flag with write-1-to-clear. A set in the
// same cycle as a clear wins. The request output is the flag gated by the
// external interrupt enable.
module wdt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    // Flag register: set on a timer event, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/dual_watchdog.sv
// dual_watchdog: top of the dual-mode watchdog / interval timer. It holds the
// control fields, applies the watchdog lock and routes counter events to
// either the reset pulse or the interrupt flag. Assumes tick_i is a one-cycle
// pulse already synchronised to clk.
module dual_watchdog #(
    parameter int CNT_W      = 15,
    parameter int WIN_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       lp_entry_i,
    input  logic       wr_i,
    input  logic       wr_enable_i,
    input  logic       wr_mode_i,
    input  logic [1:0] wr_intsel_i,
    input  logic [3:0] wr_clr_i,
    input  logic       irq_en_i,
    input  logic       flag_clr_i,
    output logic       sys_rst_o,
    output logic       irq_flag_o,
    output logic       irq_o
);
    import wdt_pkg::*;

    logic       en_q;
    logic       mode_q;
    logic [1:0] sel_q;
    logic       rst_q;
    logic       locked;
    logic       key_pending;
    logic       key_done;
    logic       cnt_match;
    logic       cnt_clear;
    logic       tmr_clr;
    logic       timeout;
    logic       tmr_event;

    // Decode of lock state and of the events that act on the counter.
    always_comb begin
        locked    = en_q && (mode_q == MODE_WD);
        tmr_clr   = wr_i && en_q && (mode_q == MODE_TMR) && wr_clr_i[0];
        cnt_clear = lp_entry_i || key_done || tmr_clr;
        timeout   = cnt_match && locked && !key_pending;
        tmr_event = cnt_match && en_q && (mode_q == MODE_TMR);
    end

    wdt_key_seq #(.WIN_CYCLES(WIN_CYCLES)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (locked),
        .wr_i      (wr_i && locked),
        .code_i    (wr_clr_i),
        .pending_o (key_pending),
        .done_o    (key_done)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (en_q),
        .tick_i  (tick_i),
        .clear_i (cnt_clear),
        .hold_i  (key_pending),
        .sel_i   (sel_q),
        .match_o (cnt_match)
    );

    wdt_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (tmr_event),
        .clr_i    (flag_clr_i),
        .irq_en_i (irq_en_i),
        .flag_o   (irq_flag_o),
        .irq_o    (irq_o)
    );

    // Control fields and reset pulse; a timeout returns to power-on state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= MODE_WD;
            sel_q  <= 2'd0;
            rst_q  <= 1'b0;
        end else begin
            rst_q <= timeout;
            if (timeout) begin
                en_q   <= 1'b0;
                mode_q <= MODE_WD;
                sel_q  <= 2'd0;
            end else if (wr_i) begin
                sel_q <= wr_intsel_i;
                if (!locked) begin
                    en_q   <= wr_enable_i;
                    mode_q <= wr_mode_i;
                end
            end
        end
    end

    assign sys_rst_o = rst_q;
endmodule

// File: rtl/wdt_checker.sv
// wdt_checker: temporal properties of dual_watchdog, bound to every instance.
// Observes the ports and the enable/mode state of the top module.
module wdt_checker (
    input logic clk,
    input logic rst_n,
    input logic sys_rst_o,
    input logic irq_flag_o,
    input logic flag_clr_i,
    input logic en_q,
    input logic mode_q
);
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o); // R3

    AST_RST_FROM_WATCHDOG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> ($past(en_q) && !$past(mode_q))); // R3

    AST_IDLE_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (!en_q && !mode_q)); // R4

    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !mode_q) |=> ((en_q && !mode_q) || sys_rst_o)); // R5

    AST_FLAG_TIMER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag_o) |-> $past(mode_q)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !flag_clr_i) |=> irq_flag_o); // R9
endmodule

bind dual_watchdog wdt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_rst_o  (sys_rst_o),
    .irq_flag_o (irq_flag_o),
    .flag_clr_i (flag_clr_i),
    .en_q       (en_q),
    .mode_q     (mode_q)
);

// File: tb/tb_dual_watchdog.sv
// tb_dual_watchdog: directed scenarios, one task each, checked at the ports.
module tb_dual_watchdog;
    localparam int WIN = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       lp_entry_i = 1'b0;
    logic       wr_i = 1'b0;
    logic       wr_enable_i = 1'b0;
    logic       wr_mode_i = 1'b0;
    logic [1:0] wr_intsel_i = 2'd0;
    logic [3:0] wr_clr_i = 4'd0;
    logic       irq_en_i = 1'b0;
    logic       flag_clr_i = 1'b0;
    logic       sys_rst_o;
    logic       irq_flag_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    int rst_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_watchdog #(.CNT_W(15), .WIN_CYCLES(WIN)) dut (
        .clk, .rst_n, .tick_i, .lp_entry_i, .wr_i, .wr_enable_i, .wr_mode_i,
        .wr_intsel_i, .wr_clr_i, .irq_en_i, .flag_clr_i,
        .sys_rst_o, .irq_flag_o, .irq_o
    );

    // Count reset pulses, sampled away from the active edge.
    always @(negedge clk) if (sys_rst_o) rst_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        irq_en_i = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic do_write(input bit en, input bit mode, input logic [1:0] sel,
                            input logic [3:0] clr);
        wr_i = 1'b1; wr_enable_i = en; wr_mode_i = mode;
        wr_intsel_i = sel; wr_clr_i = clr;
        @(negedge clk);
        wr_i = 1'b0; wr_clr_i = 4'd0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick_i = 1'b1;
            repeat (n) @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    // R1: idle after reset.
    task automatic t_reset_state();
        int base;
        do_reset();
        base = rst_cnt;
        chk("R1 rst low", sys_rst_o, 0);
        chk("R1 flag low", irq_flag_o, 0);
        chk("R1 irq low", irq_o, 0);
        ticks(300);
        wait_cyc(1);
        chk("R1 no reset while disabled", rst_cnt - base, 0);
        chk("R1 no flag while disabled", irq_flag_o, 0);
    endtask

    // R2 R3 R4: watchdog timeout at 64 ticks, pulse width, return to idle.
    task automatic t_wd_timeout();
        int base;
        do_reset();
        base = rst_cnt;
        do_write(1, 0, 2'd0, 4'd0);
        ticks(63);
        chk("R2 no reset at 63", rst_cnt - base, 0);
        ticks(1);
        wait_cyc(1);
        chk("R3 one reset pulse at 64", rst_cnt - base, 1);
        chk("R3 pulse ended", sys_rst_o, 0);
        chk("R3 no flag in watchdog", irq_flag_o, 0);
        ticks(200);
        wait_cyc(1);
        chk("R4 idle after reset", rst_cnt - base, 1);
    endtask

    // R5: lock ignores enable/mode, interval still writable (512).
    task automatic t_lock();
        int base;
        do_reset();
        base = rst_cnt;
        do_write(1, 0, 2'd0, 4'd0);
        do_write(0, 1, 2'd1, 4'd0);
        ticks(511);
        wait_cyc(1);
        chk("R5 interval moved to 512", rst_cnt - base, 0);
        ticks(1);
        wait_cyc(1);
        chk("R5 still watchdog after disable write", rst_cnt - base, 1);
        chk("R5 no flag", irq_flag_o, 0);
    endtask

    // R6: key sequence at offset 4 and at the last window cycle.
    task automatic t_key_ok(input int gap, input string tag);
        int base;
        do_reset();
        base = rst_cnt;
        do_write(1, 0, 2'd0, 4'd0);
        ticks(60);
        do_write(1, 0, 2'd0, 4'b1010);
        wait_cyc(gap - 1);
        do_write(1, 0, 2'd0, 4'b0101);
        ticks(63);
        wait_cyc(1);
        chk({"R6 cleared, no reset ", tag}, rst_cnt - base, 0);
        ticks(1);
        wait_cyc(1);
        chk({"R6 reset 64 after clear ", tag}, rst_cnt - base, 1);
    endtask

    // R7: wrong code in between, and a second key that is late.
    task automatic t_key_bad();
        int base;
        do_reset();
        base = rst_cnt;
        do_write(1, 0, 2'd0, 4'd0);
        ticks(60);
        do_write(1, 0, 2'd0, 4'b1010);
        do_write(1, 0, 2'd0, 4'b0011);
        do_write(1, 0, 2'd0, 4'b0101);
        ticks(3);
        wait_cyc(1);
        chk("R7 wrong code no early reset", rst_cnt - base, 0);
        ticks(1);
        wait_cyc(1);
        chk("R7 wrong code cancels clear", rst_cnt - base, 1);

        do_reset();
        base = rst_cnt;
        do_write(1, 0, 2'd0, 4'd0);
        ticks(60);
        do_write(1, 0, 2'd0, 4'b1010);
        wait_cyc(WIN);
        do_write(1, 0, 2'd0, 4'b0101);
        ticks(3);
        wait_cyc(1);
        chk("R7 late key no early reset", rst_cnt - base, 0);
        ticks(1);
        wait_cyc(1);
        chk("R7 late key rejected", rst_cnt - base, 1);
    endtask

    // R8: sequence pending across the timeout.
    task automatic t_pending_timeout();
        int base;
        do_reset();
        base = rst_cnt;
        do_write(1, 0, 2'd0, 4'd0);
        ticks(63);
        do_write(1, 0, 2'd0, 4'b1010);
        ticks(3);
        wait_cyc(1);
        chk("R8 reset held while pending", rst_cnt - base, 0);
        do_write(1, 0, 2'd0, 4'b0101);
        ticks(63);
        wait_cyc(1);
        chk("R8 cleared after late completion", rst_cnt - base, 0);
        ticks(1);
        wait_cyc(1);
        chk("R8 next timeout", rst_cnt - base, 1);

        do_reset();
        base = rst_cnt;
        do_write(1, 0, 2'd0, 4'd0);
        ticks(63);
        do_write(1, 0, 2'd0, 4'b1010);
        ticks(WIN - 1);
        wait_cyc(1);
        chk("R8 held inside window", rst_cnt - base, 0);
        ticks(3);
        wait_cyc(1);
        chk("R8 reset after window expiry", rst_cnt - base, 1);
    endtask

    // R9: timer flag, gating, sticky clear, periodic wrap, no reset.
    task automatic t_timer();
        int base;
        do_reset();
        base = rst_cnt;
        do_write(1, 1, 2'd0, 4'd0);
        ticks(63);
        chk("R9 no flag at 63", irq_flag_o, 0);
        ticks(1);
        chk("R9 flag at 64", irq_flag_o, 1);
        chk("R9 irq masked", irq_o, 0);
        irq_en_i = 1'b1;
        wait_cyc(1);
        chk("R9 irq when enabled", irq_o, 1);
        wait_cyc(5);
        chk("R9 flag sticky", irq_flag_o, 1);
        flag_clr_i = 1'b1;
        wait_cyc(1);
        flag_clr_i = 1'b0;
        chk("R9 flag cleared", irq_flag_o, 0);
        chk("R9 irq drops", irq_o, 0);
        ticks(63);
        chk("R9 wrapped, no flag at 63", irq_flag_o, 0);
        ticks(1);
        chk("R9 periodic flag", irq_flag_o, 1);
        chk("R9 no reset in timer mode", rst_cnt - base, 0);
    endtask

    // R10: timer clear via clear bit 0.
    task automatic t_timer_clr();
        do_reset();
        do_write(1, 1, 2'd0, 4'd0);
        ticks(40);
        do_write(1, 1, 2'd0, 4'b0001);
        ticks(63);
        chk("R10 cleared, no flag", irq_flag_o, 0);
        ticks(1);
        chk("R10 flag 64 after clear", irq_flag_o, 1);
    endtask

    // R11: stop and restart from zero.
    task automatic t_timer_stop();
        do_reset();
        do_write(1, 1, 2'd0, 4'd0);
        ticks(40);
        do_write(0, 1, 2'd0, 4'd0);
        ticks(100);
        chk("R11 stopped", irq_flag_o, 0);
        do_write(1, 1, 2'd0, 4'd0);
        ticks(63);
        chk("R11 restart from zero", irq_flag_o, 0);
        ticks(1);
        chk("R11 flag after restart", irq_flag_o, 1);
    endtask

    // R12: low-power entry clears the count.
    task automatic t_lp();
        int base;
        do_reset();
        base = rst_cnt;
        do_write(1, 0, 2'd0, 4'd0);
        ticks(60);
        lp_entry_i = 1'b1;
        wait_cyc(1);
        lp_entry_i = 1'b0;
        ticks(63);
        wait_cyc(1);
        chk("R12 count zeroed", rst_cnt - base, 0);
        ticks(1);
        wait_cyc(1);
        chk("R12 timeout after lp", rst_cnt - base, 1);
    endtask

    // R2: the two long intervals in timer mode.
    task automatic t_long_intervals();
        do_reset();
        do_write(1, 1, 2'd2, 4'd0);
        ticks(8191);
        chk("R2 8192 not yet", irq_flag_o, 0);
        ticks(1);
        chk("R2 8192 reached", irq_flag_o, 1);
        do_reset();
        do_write(1, 1, 2'd3, 4'd0);
        ticks(32767);
        chk("R2 32768 not yet", irq_flag_o, 0);
        ticks(1);
        chk("R2 32768 reached", irq_flag_o, 1);
    endtask

    // R13: interval lowered below the current count.
    task automatic t_shrink();
        do_reset();
        do_write(1, 1, 2'd3, 4'd0);
        ticks(1000);
        do_write(1, 1, 2'd0, 4'd0);
        chk("R13 no flag before tick", irq_flag_o, 0);
        ticks(1);
        chk("R13 flag on next tick", irq_flag_o, 1);
    endtask

    initial begin
        t_reset_state();
        t_wd_timeout();
        t_lock();
        t_key_ok(4, "gap4");
        t_key_ok(WIN, "gapmax");
        t_key_bad();
        t_pending_timeout();
        t_timer();
        t_timer_clr();
        t_timer_stop();
        t_lp();
        t_long_intervals();
        t_shrink();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule